// File: doc/BRIEF.md
# Shared-RAM Host Bus Interface

This block lets a 16-bit host processor reach a 4K-word shared RAM and a small file of 16-bit registers that a protocol engine also uses. The host asks for an access by pulling its select and strobe inputs low. The block then waits until the engine is off the RAM and runs a transfer with fixed phases. An active-low I/O-enable output marks the transfer window. An active-low ready output acknowledges the host once the data has been taken in or put out.

Two strap inputs set the block up for the attached host. The first picks which level of the read/write input means "write". The second picks handshake mode or zero-wait mode. In handshake mode ready acts as a normal acknowledge, and the host holds strobe until it sees it. In zero-wait mode ready rests low and works as a busy flag: it goes high once the host lets go of strobe before the transfer has finished, so hosts with no wait-state input can end their strobe early. A single request input stands in for the protocol engine. While that input is high, host transfers are held back.

Top module: `shram_host_port`

## Requirements
- R1: A transfer is requested only when `sel_n` and `strb_n` are both low at a rising clock edge. When `eng_req` is also low at that edge, `io_en_n` goes low right after it. At rest `io_en_n` is high.
- R2: At a rising edge where `eng_req` is high, no transfer starts (the engine wins ties). A request seen while the engine is busy stays pending, even if strobe is later released. It starts at the first rising edge where `eng_req` is low.
- R3: The write decision and `mem_sel` are sampled on the first falling clock edge after `io_en_n` goes low. Later changes to `rw` and `mem_sel` have no effect on that transfer.
- R4: The transfer address is sampled on the first rising edge after `io_en_n` goes low. A pulse on `addr_lat` at any earlier rising edge captures `addr` instead, and that held address is used by the next transfer only.
- R5: In handshake mode (`hs_mode`=1), `ready_n` rests high and goes low after the third rising edge after `io_en_n` falls, with read data already on `rdata`. `io_en_n` returns high one clock after that. `ready_n` returns high after the first rising edge at which `strb_n` is high.
- R6: In zero-wait mode (`hs_mode`=0), `ready_n` rests low. It goes high after the first rising edge with `strb_n` high while a request is pending or in its first two phases. It goes low again on the same edge at which handshake mode would assert ready.
- R7: With `wr_high`=0, `rw`=0 means write and `rw`=1 means read. With `wr_high`=1 the sense is reversed.
- R8: `mem_sel`=1 selects the RAM of 2^ADDR_W words (4096 by default), addressed by all 12 bits of the address.
- R9: `mem_sel`=0 selects a file of REG_WORDS registers (8 by default), indexed by address bits [2:0]. It is separate from the RAM, and reset clears it to zero.
- R10: After a transfer completes, no new transfer starts until `strb_n` has been seen high at a rising edge.
- R11: `rdata` resets to zero, is loaded only by reads, and holds its value through writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | Strap: 1 handshake mode, 0 zero-wait mode |
| wr_high | input | 1 | Strap: 1 means `rw` high writes, 0 means `rw` low writes |
| eng_req | input | 1 | Protocol engine is using the RAM |
| sel_n | input | 1 | Host select, active low |
| strb_n | input | 1 | Host strobe, active low |
| rw | input | 1 | Host read/write, sense set by `wr_high` |
| mem_sel | input | 1 | 1 RAM, 0 register file |
| addr_lat | input | 1 | Capture `addr` ahead of the transfer |
| addr | input | 12 | Host word address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data, held until the next read |
| io_en_n | output | 1 | Low during the transfer window |
| ready_n | output | 1 | Acknowledge (handshake) or busy flag (zero-wait) |

## Verification
The bench changes the address, the read/write input and the space select one clock after the transfer starts. A design that sampled them late would write the wrong word or turn a read into a write, and a later read would expose it. It also holds the engine request across a pending host request, and in zero-wait mode it releases strobe while the engine is still busy. A design that dropped the pending request or started early would show the wrong start latency. It checks that strobe held past completion does not start a second transfer, that a latched address is used once and then forgotten, and that the RAM and the register file stay apart at equal addresses. A stuck or mistimed ready shows up in the per-edge ready checks and in the data the scoreboard compares at each completion.

// File: rtl/shram_host_pkg.sv
`timescale 1ns/1ps
package shram_host_pkg;

    // Transfer sequencer states; the order of the window states is the
    // order of the fixed phases.
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_WAIT   = 3'd1,
        S_CTRL   = 3'd2,
        S_ACCESS = 3'd3,
        S_SETTLE = 3'd4,
        S_ACK    = 3'd5,
        S_HOLD   = 3'd6
    } host_state_t;

    // Control captured for one transfer.
    typedef struct packed {
        logic is_wr;
        logic is_mem;
    } xfer_ctl_t;

    function automatic logic decode_write(input logic rw_lvl, input logic wr_is_high);
        return wr_is_high ? rw_lvl : ~rw_lvl;
    endfunction

    function automatic logic in_window(input host_state_t s);
        return (s == S_CTRL) || (s == S_ACCESS) || (s == S_SETTLE) || (s == S_ACK);
    endfunction

    function automatic logic early_phase(input host_state_t s);
        return (s == S_WAIT) || (s == S_CTRL) || (s == S_ACCESS);
    endfunction

endpackage

// File: rtl/shram_host_seq.sv
`timescale 1ns/1ps
module shram_host_seq
    import shram_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hs_mode,
    input  logic        sel_n,
    input  logic        strb_n,
    input  logic        eng_req,
    output host_state_t st,
    output logic        ready_n,
    output logic        io_en_n
);

    host_state_t nxt;
    logic        host_req;

    assign host_req = ~sel_n & ~strb_n;

    always_comb begin
        nxt = st;
        case (st)
            S_IDLE:   if (host_req) nxt = eng_req ? S_WAIT : S_CTRL;
            S_WAIT:   if (!eng_req) nxt = S_CTRL;
            S_CTRL:   nxt = S_ACCESS;
            S_ACCESS: nxt = S_SETTLE;
            S_SETTLE: nxt = S_ACK;
            S_ACK:    nxt = strb_n ? S_IDLE : S_HOLD;
            S_HOLD:   nxt = strb_n ? S_IDLE : S_HOLD;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nxt;
    end

    // Ready: acknowledge in handshake mode, busy flag in zero-wait mode.
    always_ff @(posedge clk) begin
        if (rst) begin
            ready_n <= hs_mode;
        end else if (st == S_SETTLE) begin
            ready_n <= 1'b0;
        end else if (hs_mode) begin
            if ((st == S_ACK || st == S_HOLD) && strb_n) ready_n <= 1'b1;
        end else begin
            if (early_phase(st) && strb_n) ready_n <= 1'b1;
        end
    end

    assign io_en_n = ~in_window(st);

endmodule

// File: rtl/shram_host_capture.sv
`timescale 1ns/1ps
module shram_host_capture
    import shram_host_pkg::*;
#(
    parameter int ADDR_W = 12
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_win,
    input  logic              addr_take,
    input  logic              held_clr,
    input  logic              rw,
    input  logic              mem_sel,
    input  logic              wr_high,
    input  logic              addr_lat,
    input  logic [ADDR_W-1:0] addr,
    output xfer_ctl_t         ctl,
    output logic [ADDR_W-1:0] xaddr
);

    logic [ADDR_W-1:0] held_addr;
    logic              held_vld;

    // Half-cycle control capture: falling edge inside the first phase.
    always_ff @(negedge clk) begin
        if (rst) begin
            ctl.is_wr  <= 1'b0;
            ctl.is_mem <= 1'b0;
        end else if (ctl_win) begin
            ctl.is_wr  <= decode_write(rw, wr_high);
            ctl.is_mem <= mem_sel;
        end
    end

    // Early address capture, consumed by one transfer.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_vld  <= 1'b0;
            held_addr <= '0;
        end else if (addr_lat) begin
            held_vld  <= 1'b1;
            held_addr <= addr;
        end else if (held_clr) begin
            held_vld  <= 1'b0;
        end
    end

    // Full-cycle address capture at the end of the first phase.
    always_ff @(posedge clk) begin
        if (rst)            xaddr <= '0;
        else if (addr_take) xaddr <= held_vld ? held_addr : addr;
    end

endmodule

// File: rtl/shram_host_store.sv
`timescale 1ns/1ps
module shram_host_store
    import shram_host_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int REG_WORDS = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  xfer_ctl_t         ctl,
    input  logic [ADDR_W-1:0] xaddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int RAM_WORDS = 1 << ADDR_W;
    localparam int REG_AW    = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1;

    logic [DATA_W-1:0]    ram  [RAM_WORDS];
    logic [DATA_W-1:0]    regs [REG_WORDS];
    logic [REG_WORDS-1:0] reg_we;
    logic [REG_AW-1:0]    ridx;
    logic                 ram_we;
    logic                 rd_en;

    assign ridx   = xaddr[REG_AW-1:0];
    assign ram_we = acc_en & ctl.is_wr & ctl.is_mem;
    assign rd_en  = acc_en & ~ctl.is_wr;

    for (genvar g = 0; g < REG_WORDS; g++) begin : g_reg_we
        assign reg_we[g] = acc_en & ctl.is_wr & ~ctl.is_mem & (ridx == REG_AW'(g));
    end

    always_ff @(posedge clk) begin
        if (ram_we) ram[xaddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_WORDS; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < REG_WORDS; i++)
                if (reg_we[i]) regs[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= ctl.is_mem ? ram[xaddr] : regs[ridx];
    end

endmodule

// File: rtl/shram_host_port.sv
`timescale 1ns/1ps
module shram_host_port
    import shram_host_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int REG_WORDS = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_mode,
    input  logic              wr_high,
    input  logic              eng_req,
    input  logic              sel_n,
    input  logic              strb_n,
    input  logic              rw,
    input  logic              mem_sel,
    input  logic              addr_lat,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              io_en_n,
    output logic              ready_n
);

    host_state_t       st;
    xfer_ctl_t         ctl;
    logic [ADDR_W-1:0] xaddr;
    logic              in_ctrl;
    logic              in_access;
    logic              in_ack;

    assign in_ctrl   = (st == S_CTRL);
    assign in_access = (st == S_ACCESS);
    assign in_ack    = (st == S_ACK);

    shram_host_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .hs_mode (hs_mode),
        .sel_n   (sel_n),
        .strb_n  (strb_n),
        .eng_req (eng_req),
        .st      (st),
        .ready_n (ready_n),
        .io_en_n (io_en_n)
    );

    shram_host_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .ctl_win   (in_ctrl),
        .addr_take (in_ctrl),
        .held_clr  (in_ack),
        .rw        (rw),
        .mem_sel   (mem_sel),
        .wr_high   (wr_high),
        .addr_lat  (addr_lat),
        .addr      (addr),
        .ctl       (ctl),
        .xaddr     (xaddr)
    );

    shram_host_store #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .REG_WORDS (REG_WORDS)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .acc_en (in_access),
        .ctl    (ctl),
        .xaddr  (xaddr),
        .wdata  (wdata),
        .rdata  (rdata)
    );

endmodule

// File: rtl/shram_host_port_chk.sv
`timescale 1ns/1ps
module shram_host_port_chk
    import shram_host_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        hs_mode,
    input logic        eng_req,
    input logic        strb_n,
    input logic        io_en_n,
    input logic        ready_n,
    input host_state_t st,
    input xfer_ctl_t   ctl
);

    // R2: an engine request at an idle edge keeps the window closed
    p_engine_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_req && io_en_n) |=> io_en_n);

    // R3: captured control does not move after the first phase
    p_ctl_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_ACCESS) |=> $stable(ctl));

    // R5: ready falls three edges after the window opens
    p_ready_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (hs_mode && $fell(io_en_n)) |-> ##3 $fell(ready_n));

    // R5: window closes one clock after ready asserts
    p_window_close_r5: assert property (@(posedge clk) disable iff (rst)
        (hs_mode && !io_en_n && !ready_n) |=> io_en_n);

    // R5: handshake ready rests high
    p_hs_rest_r5: assert property (@(posedge clk) disable iff (rst)
        (hs_mode && st == S_IDLE) |-> ready_n);

    // R6: zero-wait ready rests low
    p_zw_rest_r6: assert property (@(posedge clk) disable iff (rst)
        (!hs_mode && st == S_IDLE) |-> !ready_n);

    // R10: a held strobe after completion does not start another window
    p_no_retrigger_r10: assert property (@(posedge clk) disable iff (rst)
        (st == S_HOLD && !strb_n) |=> io_en_n);

endmodule

bind shram_host_port shram_host_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .hs_mode (hs_mode),
    .eng_req (eng_req),
    .strb_n  (strb_n),
    .io_en_n (io_en_n),
    .ready_n (ready_n),
    .st      (st),
    .ctl     (ctl)
);

// File: tb/tb_shram_host_port.sv
`timescale 1ns/1ps
module tb_shram_host_port;

    localparam int DW = 16;
    localparam int AW = 12;
    localparam int RW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, hs_mode, wr_high, eng_req, sel_n, strb_n, rw, mem_sel, addr_lat;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic          io_en_n, ready_n;

    shram_host_port #(.DATA_W(DW), .ADDR_W(AW), .REG_WORDS(RW)) dut (
        .clk(clk), .rst(rst), .hs_mode(hs_mode), .wr_high(wr_high), .eng_req(eng_req),
        .sel_n(sel_n), .strb_n(strb_n), .rw(rw), .mem_sel(mem_sel), .addr_lat(addr_lat),
        .addr(addr), .wdata(wdata), .rdata(rdata), .io_en_n(io_en_n), .ready_n(ready_n)
    );

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    item_t         sq[$];
    int            checks = 0;
    int            fails  = 0;
    bit            done_flag = 1'b0;
    logic [DW-1:0] m_ram [1 << AW];
    logic [DW-1:0] m_reg [RW];
    logic [DW-1:0] last_rd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    // Scoreboard monitor: each window close pops one expected rdata value.
    initial begin
        logic  prev;
        item_t it;
        prev = 1'b1;
        forever begin
            tick();
            if (rst) begin
                prev = 1'b1;
            end else begin
                if (prev == 1'b0 && io_en_n == 1'b1) begin
                    if (sq.size() == 0) begin
                        checks++;
                        fails++;
                        $display("FAIL R5 unexpected completion actual=1 expected=0");
                    end else begin
                        it = sq.pop_front();
                        chk(it.tag, rdata, it.exp);
                    end
                end
                prev = io_en_n;
            end
        end
    end

    task automatic do_reset(input logic mode);
        rst = 1'b1; hs_mode = mode; sel_n = 1'b1; strb_n = 1'b1; eng_req = 1'b0;
        addr_lat = 1'b0; rw = 1'b1; mem_sel = 1'b1; addr = '0; wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        for (int i = 0; i < RW; i++) m_reg[i] = '0;
        last_rd = '0;
        chk("R1 reset io_en_n", io_en_n, 1'b1);
        chk("R5/R6 reset ready_n", ready_n, mode);
        chk("R11 reset rdata", rdata, 16'h0000);
    endtask

    task automatic latch_addr(input logic [AW-1:0] a);
        addr = a; addr_lat = 1'b1;
        tick();
        addr_lat = 1'b0;
    endtask

    // One host transfer; tgt is the address expected to be used.
    task automatic xfer(input bit is_mem, input bit is_wr, input logic [AW-1:0] a,
                        input logic [AW-1:0] tgt, input logic [DW-1:0] d,
                        input int eng_hold, input string tag);
        item_t it;
        int    n;
        if (is_wr) begin
            if (is_mem) m_ram[tgt] = d; else m_reg[tgt[2:0]] = d;
            it.exp = last_rd;
        end else begin
            it.exp  = is_mem ? m_ram[tgt] : m_reg[tgt[2:0]];
            last_rd = it.exp;
        end
        it.tag = {tag, " R11 rdata"};
        sq.push_back(it);
        mem_sel = is_mem; rw = wr_high ? is_wr : ~is_wr; addr = a; wdata = d;
        eng_req = (eng_hold > 0);
        sel_n = 1'b0; strb_n = 1'b0;
        n = 0;
        do begin
            tick();
            n++;
            if (n == eng_hold) eng_req = 1'b0;
            if (!hs_mode && n == 1) begin strb_n = 1'b1; sel_n = 1'b1; end
        end while (io_en_n === 1'b1 && n < 50);
        chk({tag, " R2 start edge count"}, n, eng_hold + 1);
        if (hs_mode) chk({tag, " R5 ready before phases"}, ready_n, 1'b1);
        tick();
        // R3 R4: late changes must not affect this transfer
        addr = ~a; rw = ~rw; mem_sel = ~is_mem;
        chk({tag, " R5/R6 ready phase1"}, ready_n, 1'b1);
        tick();
        chk({tag, " R5/R6 ready phase2"}, ready_n, 1'b1);
        tick();
        chk({tag, " R5/R6 ready asserted"}, ready_n, 1'b0);
        chk({tag, " R1 window open"}, io_en_n, 1'b0);
        tick();
        chk({tag, " R5 window closed"}, io_en_n, 1'b1);
        chk({tag, " R5/R6 ready held"}, ready_n, 1'b0);
        if (hs_mode) begin
            tick();
            chk({tag, " R10 no retrigger"}, io_en_n, 1'b1);
            chk({tag, " R5 ready until strobe"}, ready_n, 1'b0);
            strb_n = 1'b1; sel_n = 1'b1;
            tick();
            chk({tag, " R5 ready released"}, ready_n, 1'b1);
        end
        eng_req = 1'b0;
    endtask

    initial begin
        wr_high = 1'b0;
        do_reset(1'b1);

        xfer(1'b0, 1'b0, 12'h005, 12'h005, 16'h0, 0, "R9 reg reset read");

        // R1: strobe without select, select without strobe
        sel_n = 1'b1; strb_n = 1'b0;
        repeat (3) begin tick(); chk("R1 strobe only", io_en_n, 1'b1); end
        sel_n = 1'b0; strb_n = 1'b1;
        repeat (3) begin tick(); chk("R1 select only", io_en_n, 1'b1); end
        sel_n = 1'b1;
        tick();

        // R7 R8: writes with rw low
        xfer(1'b1, 1'b1, 12'h000, 12'h000, 16'h1234, 0, "R8 wr low");
        xfer(1'b1, 1'b1, 12'hFFF, 12'hFFF, 16'hABCD, 0, "R8 wr top");
        xfer(1'b0, 1'b1, 12'h003, 12'h003, 16'h5A5A, 0, "R9 reg wr");
        xfer(1'b1, 1'b1, 12'h003, 12'h003, 16'h0F0F, 0, "R8 ram wr same addr");
        xfer(1'b0, 1'b0, 12'h003, 12'h003, 16'h0, 0, "R9 reg rd");
        xfer(1'b1, 1'b0, 12'h003, 12'h003, 16'h0, 0, "R8 ram rd");
        xfer(1'b1, 1'b0, 12'hFFF, 12'hFFF, 16'h0, 0, "R8 ram rd top");
        xfer(1'b1, 1'b1, 12'h010, 12'h010, 16'h2222, 0, "R11 wr keeps rdata");

        // R2: engine busy for three edges
        xfer(1'b1, 1'b0, 12'h000, 12'h000, 16'h0, 3, "R2 engine wait rd");

        // R4: early address capture, used once
        xfer(1'b1, 1'b1, 12'h456, 12'h456, 16'h1111, 0, "R4 prep");
        latch_addr(12'h123);
        tick();
        xfer(1'b1, 1'b1, 12'h456, 12'h123, 16'h7777, 0, "R4 latched wr");
        xfer(1'b1, 1'b0, 12'h123, 12'h123, 16'h0, 0, "R4 latched rd");
        xfer(1'b1, 1'b0, 12'h456, 12'h456, 16'h0, 0, "R4 latch cleared rd");

        // R7: reversed read/write sense
        wr_high = 1'b1;
        xfer(1'b1, 1'b1, 12'h200, 12'h200, 16'hBEEF, 0, "R7 wr high");
        xfer(1'b1, 1'b0, 12'h200, 12'h200, 16'h0, 0, "R7 rd low");

        // R6: zero-wait mode with early strobe release
        do_reset(1'b0);
        xfer(1'b1, 1'b1, 12'h300, 12'h300, 16'hC0DE, 0, "R6 zw wr");
        chk("R6 rest after wr", ready_n, 1'b0);
        xfer(1'b1, 1'b0, 12'h300, 12'h300, 16'h0, 0, "R6 zw rd");
        xfer(1'b1, 1'b0, 12'h200, 12'h200, 16'h0, 2, "R6 R2 zw pending rd");
        tick();
        chk("R6 rest after pending", ready_n, 1'b0);

        repeat (3) tick();
        chk("R5 scoreboard drained", sq.size(), 0);
        summary();
        $finish;
    end

    initial begin
        #2000000;
        if (!done_flag) begin
            fails++;
            $display("FAIL R5 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

endmodule